// File: doc/BRIEF.md
# Channel Interrupt Mask Controller

This block collects completion events from a multi-channel DMA engine and turns them into a single interrupt line for the host. There are three event groups: one bit per transmit channel, one bit per receive channel, and a DMA-level group whose only live bit reports a host error. Each group has a sticky raw status, an enable mask and a masked status. A single level-sensitive interrupt output is the OR of every masked bit.

Software changes a mask through two write-only views. One sets the mask bits written as one and the other clears them, so no read-modify-write is needed. The channel logic clears raw bits with a per-bit acknowledge. A vector register collects all masked bits in one word. An end-of-interrupt write drops the output for one cycle, so that a condition still pending gives the interrupt controller a new rising edge. Reads are combinational on a simple 32-bit address/data port.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every raw, mask and masked bit is zero, `irq_o` is low and every register offset reads zero.
- R2: A one-cycle pulse on an event input bit sets the raw bit of the same index at the next clock edge. Transmit raw reads at 0x80, receive raw at 0xA0 and DMA-level raw at 0xB0, where the host error is bit 1.
- R3: An acknowledge input bit clears the matching raw bit at the next edge. When an event and an acknowledge for the same bit arrive in the same cycle, the event wins and the bit stays set.
- R4: Masked status reads at 0x84 (transmit), 0xA4 (receive) and 0xB4 (DMA-level) and equals raw AND mask bit for bit.
- R5: A write to a mask-set offset (0x88, 0xA8, 0xB8) sets the mask bits written as one and leaves those written as zero unchanged. Reading the set or the clear offset of a group returns its current mask.
- R6: A write to a mask-clear offset (0x8C, 0xAC, 0xBC) clears the mask bits written as one and leaves the rest unchanged. Writing all ones disables every bit of that group.
- R7: `irq_o` is high exactly when at least one masked bit of any group is set, outside the end-of-interrupt window. It follows the registered state, so it rises in the cycle after the event edge.
- R8: Any write to offset 0x94 forces `irq_o` low for the one cycle after the write edge. After that, `irq_o` returns high if a masked bit is still pending.
- R9: Offset 0x90 reads the interrupt vector: receive masked bits in [NUM_CH-1:0], transmit masked bits in [2*NUM_CH-1:NUM_CH], the host-error masked bit at 2*NUM_CH, and zero above.
- R10: Bit 0 of the DMA-level group is not implemented: its raw and mask bits always read zero. Writes to raw, masked and vector offsets have no effect, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| tx_evt_i | input | NUM_CH | Transmit completion event pulses |
| tx_ack_i | input | NUM_CH | Transmit raw-status acknowledge |
| rx_evt_i | input | NUM_CH | Receive completion event pulses |
| rx_ack_i | input | NUM_CH | Receive raw-status acknowledge |
| host_err_i | input | 1 | Host-error event pulse |
| host_err_ack_i | input | 1 | Host-error acknowledge |
| irq_o | output | 1 | Combined interrupt output |

## Verification
Assertions check on every cycle that an event always sets its raw bit, that an acknowledge without an event clears it, that mask-set and mask-clear writes reach the mask at the next edge, that masked status never exceeds raw, and that the end-of-interrupt window forces the output low. Only the bench scenarios show the register map: the offsets and bit positions read back, the masked value for many raw and mask combinations, the vector layout, the unimplemented bit, and that zero bits and read-only writes change nothing. The bench sweeps every channel of every group and checks several combined mask and event patterns against values it computes itself.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam logic [7:0] OFS_TX_RAW  = 8'h80;
  localparam logic [7:0] OFS_TX_MSK  = 8'h84;
  localparam logic [7:0] OFS_TX_SET  = 8'h88;
  localparam logic [7:0] OFS_TX_CLR  = 8'h8C;
  localparam logic [7:0] OFS_VECTOR  = 8'h90;
  localparam logic [7:0] OFS_EOI     = 8'h94;
  localparam logic [7:0] OFS_RX_RAW  = 8'hA0;
  localparam logic [7:0] OFS_RX_MSK  = 8'hA4;
  localparam logic [7:0] OFS_RX_SET  = 8'hA8;
  localparam logic [7:0] OFS_RX_CLR  = 8'hAC;
  localparam logic [7:0] OFS_DM_RAW  = 8'hB0;
  localparam logic [7:0] OFS_DM_MSK  = 8'hB4;
  localparam logic [7:0] OFS_DM_SET  = 8'hB8;
  localparam logic [7:0] OFS_DM_CLR  = 8'hBC;

  localparam int unsigned DM_W         = 2;
  localparam int unsigned HOST_ERR_BIT = 1;
  localparam logic [DM_W-1:0] DM_IMPL  = 2'b10;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned     WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] evt_i,
  input  logic [WIDTH-1:0] ack_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] raw_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] masked_o
);
  logic [WIDTH-1:0] raw_q, raw_d;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic [WIDTH-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = set_we_i ? wdata_i : '0;
    clr_bits = clr_we_i ? wdata_i : '0;
    // event has priority over acknowledge
    raw_d    = ((raw_q & ~ack_i) | evt_i) & IMPL;
    mask_d   = ((mask_q | set_bits) & ~clr_bits) & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;

  a_r4_masked_within_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & ~raw_o) == '0);

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    if (IMPL[b]) begin : g_live
      a_r2_evt_sets_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[b] |=> raw_o[b]);
      a_r3_ack_clears_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i[b] && !evt_i[b]) |=> !raw_o[b]);
      a_r5_set_reaches_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_we_i && wdata_i[b] && !clr_we_i) |=> mask_o[b]);
      a_r6_clr_reaches_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && wdata_i[b]) |=> !mask_o[b]);
    end else begin : g_dead
      a_r10_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !raw_o[b] && !mask_o[b]);
    end
  end
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic eoi_we_i,
  output logic irq_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= eoi_we_i;
  end

  assign irq_o = pending_i & ~hold_q;

  a_r8_eoi_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_we_i |=> !irq_o);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_CH-1:0] tx_evt_i,
  input  logic [NUM_CH-1:0] tx_ack_i,
  input  logic [NUM_CH-1:0] rx_evt_i,
  input  logic [NUM_CH-1:0] rx_ack_i,
  input  logic              host_err_i,
  input  logic              host_err_ack_i,
  output logic              irq_o
);
  localparam int unsigned VEC_W = 2 * NUM_CH + 1;

  logic [NUM_CH-1:0] tx_raw, tx_mask, tx_msk;
  logic [NUM_CH-1:0] rx_raw, rx_mask, rx_msk;
  logic [DM_W-1:0]   dm_raw, dm_mask, dm_msk;
  logic [DM_W-1:0]   dm_evt, dm_ack;
  logic [VEC_W-1:0]  vector;
  logic              any_pending;
  logic              unused_wdata;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign unused_wdata = ^reg_wdata_i;

  irq_group #(.WIDTH(NUM_CH), .IMPL({NUM_CH{1'b1}})) i_tx_grp (
    .clk_i, .rst_ni,
    .evt_i    (tx_evt_i),
    .ack_i    (tx_ack_i),
    .set_we_i (reg_we_i && hit(reg_addr_i, OFS_TX_SET)),
    .clr_we_i (reg_we_i && hit(reg_addr_i, OFS_TX_CLR)),
    .wdata_i  (reg_wdata_i[NUM_CH-1:0]),
    .raw_o    (tx_raw),
    .mask_o   (tx_mask),
    .masked_o (tx_msk)
  );

  irq_group #(.WIDTH(NUM_CH), .IMPL({NUM_CH{1'b1}})) i_rx_grp (
    .clk_i, .rst_ni,
    .evt_i    (rx_evt_i),
    .ack_i    (rx_ack_i),
    .set_we_i (reg_we_i && hit(reg_addr_i, OFS_RX_SET)),
    .clr_we_i (reg_we_i && hit(reg_addr_i, OFS_RX_CLR)),
    .wdata_i  (reg_wdata_i[NUM_CH-1:0]),
    .raw_o    (rx_raw),
    .mask_o   (rx_mask),
    .masked_o (rx_msk)
  );

  always_comb begin
    dm_evt = '0;
    dm_ack = '0;
    dm_evt[HOST_ERR_BIT] = host_err_i;
    dm_ack[HOST_ERR_BIT] = host_err_ack_i;
  end

  irq_group #(.WIDTH(DM_W), .IMPL(DM_IMPL)) i_dm_grp (
    .clk_i, .rst_ni,
    .evt_i    (dm_evt),
    .ack_i    (dm_ack),
    .set_we_i (reg_we_i && hit(reg_addr_i, OFS_DM_SET)),
    .clr_we_i (reg_we_i && hit(reg_addr_i, OFS_DM_CLR)),
    .wdata_i  (reg_wdata_i[DM_W-1:0]),
    .raw_o    (dm_raw),
    .mask_o   (dm_mask),
    .masked_o (dm_msk)
  );

  assign vector      = {dm_msk[HOST_ERR_BIT], tx_msk, rx_msk};
  assign any_pending = |vector;

  irq_eoi_gate i_eoi (
    .clk_i, .rst_ni,
    .pending_i (any_pending),
    .eoi_we_i  (reg_we_i && hit(reg_addr_i, OFS_EOI)),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if      (hit(reg_addr_i, OFS_TX_RAW)) reg_rdata_o = DATA_W'(tx_raw);
    else if (hit(reg_addr_i, OFS_TX_MSK)) reg_rdata_o = DATA_W'(tx_msk);
    else if (hit(reg_addr_i, OFS_TX_SET) || hit(reg_addr_i, OFS_TX_CLR))
                                          reg_rdata_o = DATA_W'(tx_mask);
    else if (hit(reg_addr_i, OFS_RX_RAW)) reg_rdata_o = DATA_W'(rx_raw);
    else if (hit(reg_addr_i, OFS_RX_MSK)) reg_rdata_o = DATA_W'(rx_msk);
    else if (hit(reg_addr_i, OFS_RX_SET) || hit(reg_addr_i, OFS_RX_CLR))
                                          reg_rdata_o = DATA_W'(rx_mask);
    else if (hit(reg_addr_i, OFS_DM_RAW)) reg_rdata_o = DATA_W'(dm_raw);
    else if (hit(reg_addr_i, OFS_DM_MSK)) reg_rdata_o = DATA_W'(dm_msk);
    else if (hit(reg_addr_i, OFS_DM_SET) || hit(reg_addr_i, OFS_DM_CLR))
                                          reg_rdata_o = DATA_W'(dm_mask);
    else if (hit(reg_addr_i, OFS_VECTOR)) reg_rdata_o = DATA_W'(vector);
  end

  a_r7_pending_raises_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|tx_msk) || (|rx_msk) || dm_msk[HOST_ERR_BIT]) && !$past(reg_we_i && hit(reg_addr_i, OFS_EOI))
    |-> irq_o);
  a_r7_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((tx_raw & tx_mask) != '0 || (rx_raw & rx_mask) != '0 || (dm_raw[HOST_ERR_BIT] && dm_mask[HOST_ERR_BIT])));
endmodule

// File: tb/test_irq_mask_ctrl.sv
module test_irq_mask_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] tx_evt = '0, tx_ack = '0, rx_evt = '0, rx_ack = '0;
  logic        herr = 1'b0, herr_ack = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_mask_ctrl #(.NUM_CH(N)) i_irq_mask_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_evt_i(tx_evt), .tx_ack_i(tx_ack), .rx_evt_i(rx_evt), .rx_ack_i(rx_ack),
    .host_err_i(herr), .host_err_ack_i(herr_ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ev(input logic [N-1:0] t, input logic [N-1:0] r, input logic h);
    @(negedge clk); tx_evt = t; rx_evt = r; herr = h;
    @(negedge clk); tx_evt = '0; rx_evt = '0; herr = 1'b0;
  endtask

  task automatic ak(input logic [N-1:0] t, input logic [N-1:0] r, input logic h);
    @(negedge clk); tx_ack = t; rx_ack = r; herr_ack = h;
    @(negedge clk); tx_ack = '0; rx_ack = '0; herr_ack = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [14];
    offs = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'hA0, 8'hA4,
             8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 14; i++) rdchk("R1 reset read", offs[i], 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // R2/R3 per-channel sweep, mask off so irq stays low
    for (int c = 0; c < N; c++) begin
      ev(N'(1) << c, '0, 1'b0);
      rdchk("R2 tx raw bit", 8'h80, 32'h1 << c);
      rdchk("R4 tx masked with mask off", 8'h84, 32'h0);
      chk("R7 irq low with mask off", {31'b0, irq}, 32'h0);
      ak(N'(1) << c, '0, 1'b0);
      rdchk("R3 tx ack clears", 8'h80, 32'h0);
      ev('0, N'(1) << c, 1'b0);
      rdchk("R2 rx raw bit", 8'hA0, 32'h1 << c);
      rdchk("R2 tx untouched by rx", 8'h80, 32'h0);
      ak('0, N'(1) << c, 1'b0);
      rdchk("R3 rx ack clears", 8'hA0, 32'h0);
    end
    ev('0, '0, 1'b1);
    rdchk("R2 host error at bit 1", 8'hB0, 32'h2);
    ak('0, '0, 1'b1);
    rdchk("R3 host ack clears", 8'hB0, 32'h0);

    // R3 event beats same-cycle acknowledge
    ev(8'h04, '0, 1'b0);
    @(negedge clk); tx_evt = 8'h04; tx_ack = 8'h04;
    @(negedge clk); tx_evt = '0; tx_ack = '0;
    rdchk("R3 event wins over ack", 8'h80, 32'h04);
    ak(8'h04, '0, 1'b0);

    // R5/R6 mask accumulation
    wr(8'h88, 32'h0000_0011);
    rdchk("R5 tx set", 8'h88, 32'h11);
    wr(8'h88, 32'h0000_0000);
    rdchk("R5 zero write no effect", 8'h8C, 32'h11);
    wr(8'h88, 32'hFFFF_FF40);
    rdchk("R5 set accumulates", 8'h88, 32'h51);
    wr(8'h8C, 32'h0000_0001);
    rdchk("R6 clear one bit", 8'h88, 32'h50);
    wr(8'h8C, 32'h0);
    rdchk("R6 zero clear no effect", 8'h88, 32'h50);
    wr(8'h8C, 32'hFFFF_FFFF);
    rdchk("R6 all ones clears group", 8'h88, 32'h0);

    // R4/R7/R9 pattern sweep over raw x mask
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] m, r, rm, rr;
      logic hm, hr;
      m  = (p == 0) ? 8'hA5 : (p == 1) ? 8'h3C : (p == 2) ? 8'hFF : 8'h01;
      r  = m ^ 8'h0F;
      rm = ~m;
      rr = r ^ 8'hF0;
      hm = p[0];
      hr = p[1];
      wr(8'h88, {24'b0, m});
      wr(8'hA8, {24'b0, rm});
      wr(8'hB8, {30'b0, hm, 1'b0});
      ev(r, rr, hr);
      rdchk("R4 tx masked", 8'h84, {24'b0, r & m});
      rdchk("R4 rx masked", 8'hA4, {24'b0, rr & rm});
      rdchk("R4 dma masked", 8'hB4, {30'b0, hr & hm, 1'b0});
      rdchk("R9 vector", 8'h90, {15'b0, hr & hm, r & m, rr & rm});
      chk("R7 irq level", {31'b0, irq}, {31'b0, |{hr & hm, r & m, rr & rm}});
      ak('1, '1, 1'b1);
      rdchk("R3 all acked", 8'h90, 32'h0);
      chk("R7 irq low after ack", {31'b0, irq}, 32'h0);
      wr(8'h8C, '1); wr(8'hAC, '1); wr(8'hBC, '1);
    end

    // R10 unimplemented bit and read-only offsets
    wr(8'hB8, 32'h3);
    rdchk("R10 dma bit0 mask unimplemented", 8'hB8, 32'h2);
    wr(8'hBC, 32'h2);
    wr(8'h80, '1); wr(8'hA4, '1); wr(8'h90, '1);
    rdchk("R10 raw write ignored", 8'h80, 32'h0);
    rdchk("R10 masked write ignored", 8'hA4, 32'h0);
    rdchk("R10 vector write ignored", 8'h90, 32'h0);
    rdchk("R10 unmapped offset", 8'h98, 32'h0);

    // R8 end-of-interrupt re-arm
    wr(8'hA8, 32'h08);
    ev('0, 8'h08, 1'b0);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h94, 32'h0);
    chk("R8 irq low after eoi", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq re-asserts", {31'b0, irq}, 32'h1);
    ak('0, 8'h08, 1'b0);
    wr(8'h94, 32'h0);
    @(negedge clk);
    chk("R8 no re-assert when idle", {31'b0, irq}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule